// File: doc/BRIEF.md
# Clock-generator configuration I2C slave

This block is the serial configuration port of a clock generator. It is an I2C slave that holds seven byte-wide configuration registers. It presents all of them at once as one flat parallel vector, which the frequency-select and output-enable logic of the chip decodes. Both bus pins are sampled by the system clock and pass through a synchronizer and a glitch filter before START, STOP and SCL edges are recognised. The block only pulls SDA low through an open-drain enable. It never stretches SCL.

A host changes the configuration with a block write. The transaction is the write address byte, then two bytes that are acknowledged and thrown away (a command byte and a length byte), then data bytes. The data bytes land in register 0, 1, 2 and so on, strictly in order. The host may stop after any whole byte, and registers it did not reach keep their values.

A block read returns a length byte of 7 followed by registers 0 to 6. The host acknowledges each byte and ends the read with a NACK. Random register addressing is not supported in either direction.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (7-bit address 0x69, R/W bit 0 = write) and 0xD3 (R/W bit 1 = read) by pulling SDA low in the ninth clock.
- R2: For any other 7-bit address, the slave leaves SDA released in the ninth clock. It then ignores all later bytes until the next START, so no register changes and no byte is acknowledged.
- R3: In a write, the first two bytes after the address are acknowledged and their values never reach any register.
- R4: In a write, the third byte after the address goes to register 0, and each later byte goes to the next higher register.
- R5: A STOP after any whole data byte ends the write. Registers already written keep their new values and the others keep their old values.
- R6: Data bytes beyond register 6 are still acknowledged and are dropped without changing any register.
- R7: In a read, the slave sends the value 7 first, then registers 0 through 6, each byte MSB first. It moves to the next byte only after the host acknowledges.
- R8: When the host answers a read byte with NACK, the slave releases SDA and drives nothing more until the next START, so further clocks read as all ones.
- R9: After reset, register 0 holds 0x02 and registers 1 to 6 hold 0xFF (all output enables on). SDA is released.
- R10: A low pulse on SDA that lasts less than FILT_LEN system clocks while SCL is high is neither a START nor a STOP and does not disturb a transfer.
- R11: The SDA enable changes only while SCL is low, and it is released after a STOP.
- R12: Bits [8*i+7 : 8*i] of `cfg_o` always show register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 8*NUM_REGS | Register bank, register i in byte lane i |

## Verification
The assertions assume that SCL stays at each level for clearly longer than the synchronizer and filter delay. They also assume that SDA moves only while SCL is low, except for START and STOP, so that every reaction of the slave lands in an SCL-low interval. The bit-banged master in the bench keeps each phase of a bit at twelve system clocks, about twice that delay. It sets SDA in the first quarter of the low phase. The only out-of-rule SDA activity it injects is the deliberate one-clock glitch used for R10. Data values, the length of each write and the wrong addresses are drawn at random from a fixed seed. These random cases are mixed with directed empty, partial, overlong and NACK-terminated transfers.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_TACK,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/cfg_i2c_pin_filter.sv
module cfg_i2c_pin_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    typedef struct packed {
        logic [1:0]          sync;
        logic [FILT_LEN-1:0] hist;
        logic                lvl;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], pin_i};
        d.hist = {q.hist[FILT_LEN-2:0], q.sync[1]};
        if (&q.hist) begin
            d.lvl = 1'b1;
        end else if (~|q.hist) begin
            d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: '1, hist: '1, lvl: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign pin_o = q.lvl;
endmodule

// File: rtl/cfg_i2c_bus_events.sv
module cfg_i2c_bus_events #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] filt;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        cfg_i2c_pin_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (raw[g]),
            .pin_o (filt[g])
        );
    end

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = filt[0];
        d.sda = filt[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign sda_lvl   = filt[1];
    assign scl_rise  = filt[0] & ~q.scl;
    assign scl_fall  = ~filt[0] & q.scl;
    assign start_det = filt[0] & q.scl & q.sda & ~filt[1];
    assign stop_det  = filt[0] & q.scl & ~q.sda & filt[1];
endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile #(
    parameter int                  NUM_REGS  = 7,
    parameter int                  IDX_W     = 3,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      widx,
    input  logic [7:0]            wdata,
    output logic [NUM_REGS*8-1:0] bank_o
);
    logic [NUM_REGS*8-1:0] bank_d, bank_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign bank_d[g*8 +: 8] = (we && (widx == IDX_W'(g))) ? wdata : bank_q[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= RESET_VAL;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bank_o = bank_q;
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int                    NUM_REGS  = 7,
    parameter logic [6:0]            DEV_ADDR  = 7'h69,
    parameter int                    FILT_LEN  = 3,
    parameter logic [NUM_REGS*8-1:0] RESET_VAL = 56'hFF_FF_FF_FF_FF_FF_02
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int CNT_W = $clog2(NUM_REGS + 3);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NUM_REGS + 2);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2);
    localparam logic [7:0]       LEN_BYTE = 8'(NUM_REGS);

    typedef struct packed {
        phase_e          ph;
        logic [3:0]      bits;
        logic [7:0]      shreg;
        logic            rd;
        logic [CNT_W-1:0] nbyte;
        logic            oe;
    } slv_t;

    slv_t q, d;

    logic             sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic             we;
    logic [IDX_W-1:0] widx;
    logic [CNT_W-1:0] byte_ptr;

    cfg_i2c_bus_events #(.FILT_LEN(FILT_LEN)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (ev_start),
        .stop_det  (ev_stop)
    );

    cfg_i2c_regfile #(
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W),
        .RESET_VAL (RESET_VAL)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .widx   (widx),
        .wdata  (q.shreg),
        .bank_o (cfg_o)
    );

    function automatic logic [7:0] tx_byte(input logic [CNT_W-1:0] idx,
                                           input logic [NUM_REGS*8-1:0] bank);
        logic [7:0] b;
        b = 8'hFF;
        if (idx == '0) begin
            b = LEN_BYTE;
        end
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == CNT_W'(i + 1)) begin
                b = bank[i*8 +: 8];
            end
        end
        return b;
    endfunction

    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] n);
        return (n == CNT_MAX) ? n : n + CNT_W'(1);
    endfunction

    always_comb begin
        logic [CNT_W-1:0] nx;
        logic [7:0]       nb;
        d    = q;
        we   = 1'b0;
        widx = '0;
        nx   = step(q.nbyte);
        nb   = tx_byte(nx, cfg_o);
        if (ev_start) begin
            d.ph   = PH_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (ev_stop) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.ph)
                PH_ADDR, PH_RX: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.shreg = {q.shreg[6:0], sda_lvl};
                        d.bits  = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        if (q.ph == PH_ADDR) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.rd    = q.shreg[0];
                                d.nbyte = '0;
                                d.ph    = PH_ACK;
                                d.oe    = 1'b1;
                            end else begin
                                d.ph = PH_SKIP;
                            end
                        end else begin
                            if (q.nbyte >= CNT_DATA && q.nbyte < CNT_MAX) begin
                                we   = 1'b1;
                                widx = IDX_W'(q.nbyte - CNT_DATA);
                            end
                            d.nbyte = nx;
                            d.ph    = PH_ACK;
                            d.oe    = 1'b1;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_rise) begin
                        d.bits = 4'd9;
                    end else if (scl_fall && q.bits == 4'd9) begin
                        d.bits = '0;
                        if (q.rd) begin
                            d.shreg = tx_byte(q.nbyte, cfg_o);
                            d.oe    = ~d.shreg[7];
                            d.ph    = PH_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.ph = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.oe = 1'b0;
                            d.ph = PH_TACK;
                        end else begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.oe    = ~q.shreg[6];
                        end
                    end
                end
                PH_TACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            d.ph = PH_SKIP;
                        end else begin
                            d.bits = 4'd9;
                        end
                    end else if (scl_fall && q.bits == 4'd9) begin
                        d.nbyte = nx;
                        d.shreg = nb;
                        d.oe    = ~nb[7];
                        d.bits  = '0;
                        d.ph    = PH_TX;
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, bits: '0, shreg: '0, rd: 1'b0, nbyte: '0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign byte_ptr = q.nbyte;
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
    parameter int NUM_REGS = 7,
    parameter int CW       = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  stop_det,
    input logic [CW-1:0]         byte_ptr
);
    // R11: the data pin is only moved while the bus clock is low
    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R11: a STOP leaves the data pin released
    a_r11_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R12: register contents are updated only in an SCL-low interval
    a_r12_cfg_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> !scl_i);

    // R4: the byte pointer either restarts at zero or advances by one
    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_ptr) |-> (byte_ptr == '0 || byte_ptr == $past(byte_ptr) + CW'(1)));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .CW       (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o),
    .stop_det (ev_stop),
    .byte_ptr (byte_ptr)
);

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 12;
    localparam int NREG       = 7;
    localparam logic [NREG*8-1:0] DEF = 56'hFF_FF_FF_FF_FF_FF_02;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NREG*8-1:0] cfg;
    bit   glitch_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [12];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    cfg_i2c_slave u_cfg_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait();
        if (glitch_en && b) begin
            sda_m = 1'b0; @(negedge clk); sda_m = 1'b1;
        end
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~ack);
    endtask

    function automatic logic [7:0] model_rd(input int idx);
        return (idx == 0) ? 8'(NREG) : model[idx-1];
    endfunction

    task automatic chk_bank(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, cfg[i*8 +: 8], model[i]);
    endtask

    task automatic wr_txn(input logic [7:0] abyte, input int nd, input logic exp_ack);
        logic a;
        bus_start();
        send_byte(abyte, a);
        chk(exp_ack ? "R1 write address ack" : "R2 foreign address nack", a, exp_ack);
        send_byte(8'($urandom), a);
        chk(exp_ack ? "R3 command byte ack" : "R2 ignored byte", a, exp_ack);
        send_byte(8'($urandom), a);
        chk(exp_ack ? "R3 length byte ack" : "R2 ignored byte", a, exp_ack);
        for (int k = 0; k < nd; k++) begin
            send_byte(wbuf[k], a);
            chk(k < NREG ? "R4 data ack" : "R6 overflow ack", a, exp_ack);
            if (exp_ack && k < NREG) model[k] = wbuf[k];
        end
        bus_stop();
        chk("R11 released after stop", sda_oe, 1'b0);
    endtask

    task automatic rd_txn(input int nread);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, a);
        chk("R1 read address ack", a, 1'b1);
        for (int k = 0; k <= nread; k++) begin
            recv_byte(v, k != nread);
            chk("R7 read byte", v, model_rd(k));
        end
        if (nread < NREG) begin
            recv_byte(v, 1'b0);
            chk("R8 released after nack", v, 8'hFF);
        end
        bus_stop();
    endtask

    task automatic fill(input int nd);
        for (int k = 0; k < nd; k++) wbuf[k] = 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        logic [6:0] bad;
        seed = $urandom(32'd4242);
        for (int i = 0; i < NREG; i++) model[i] = DEF[i*8 +: 8];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset bank", cfg, DEF);
        chk("R9 reset sda released", sda_oe, 1'b0);

        rd_txn(NREG);                         // R7 defaults read back

        fill(NREG); wr_txn(8'hD2, NREG, 1'b1);
        chk_bank("R4 full write / R12 lanes");

        fill(3); wr_txn(8'hD2, 3, 1'b1);
        chk_bank("R5 partial write");

        wr_txn(8'hD2, 0, 1'b1);
        chk_bank("R3 header-only write");

        fill(9); wr_txn(8'hD2, 9, 1'b1);
        chk_bank("R6 overflow dropped");

        do bad = 7'($urandom); while (bad == 7'h69);
        fill(4); wr_txn({bad, 1'b0}, 4, 1'b0);
        chk_bank("R2 foreign address no change");

        glitch_en = 1'b1;
        fill(NREG); wr_txn(8'hD2, NREG, 1'b1);
        glitch_en = 1'b0;
        chk_bank("R10 glitch filtered");

        rd_txn(3);                            // R8 early NACK

        for (int it = 0; it < 4; it++) begin
            int nd;
            nd = int'($urandom % 10);
            fill(nd); wr_txn(8'hD2, nd, 1'b1);
            chk_bank("R5 random length write");
            rd_txn(NREG);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule